// File: doc/BRIEF.md
# Boot Image Retry Sequencer

This controller decides which of a small set of stored boot images is fetched and given control after a reset. It drives a loader through a request/done handshake, naming the image by index. The loader answers with a CRC verdict. A good image is recorded as the last-loaded index and then released with a one-cycle handoff pulse. A bad image makes the sequencer try the next index.

A cold reset always restarts the search at image 0 and clears all remembered history. A warm reset reads a software state word. If the word carries the agreed magic value (0x49535756), the previously loaded image is fetched again. If it does not, the sequencer advances to the following image and bumps the last-loaded index. Once every image has failed, the block asks for the alternate (programmable-fabric) boot source and refuses flash boot on any later warm reset until a cold reset arrives. If that alternate source is not available, it parks in a halt state with an error flag.

A reset event is presented as a one-cycle `boot_start` pulse qualified by `cold`. `rst_n` is the power-on reset and is equivalent to a cold start with no load issued.

Top module: `boot_retry_seq`

## Requirements
- R1: While and after `rst_n` is low, with no `boot_start`, every output is 0: `ld_req`, `ld_idx`, `handoff`, `fb_req`, `halt_err`, `last_idx` and `status`.
- R2: The cycle after a `boot_start` with `cold`=1, `ld_req` is 1 and `ld_idx` is 0.
- R3: While `ld_req` is 1, a `ld_done` pulse with `ld_crc_ok`=0 moves `ld_idx` to the next index (below the last). A pulse with `ld_crc_ok`=1 drops `ld_req` and leads to a handoff.
- R4: `handoff` is high for exactly one cycle, the cycle after a passing `ld_done`. In that cycle `last_idx` already equals the index that passed.
- R5: After a warm `boot_start` (`cold`=0, no lockout) with `sw_state` equal to 0x49535756, `ld_req` is 1 with `ld_idx` equal to the `last_idx` held before the reset.
- R6: After a warm `boot_start` with any other `sw_state` and `last_idx` below 3, `ld_idx` and `last_idx` both equal the previous `last_idx` plus one.
- R7: When image 3 fails, or when a warm reset without the magic value finds `last_idx` at 3, `status[0]` becomes 1. `fb_req` is then held at 1 if `fb_avail` is 1.
- R8: While `status[0]` is 1, a warm `boot_start` issues no `ld_req`, whatever `sw_state` holds, and returns straight to fallback or halt. A cold `boot_start` clears `status[0]` and `last_idx`.
- R9: `status[1]` is 1 from the cycle after `handoff` until the next `boot_start`. `status[11:8]` holds the source code sampled from `src_sel` at `boot_start` (NAND=0, SD/MMC=1, QSPI=2). All other status bits are 0.
- R10: When fallback is required and `fb_avail` is 0, `halt_err` is held at 1 and `fb_req` stays 0. At most one of `ld_req`, `handoff`, `fb_req` and `halt_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| boot_start | input | 1 | One-cycle pulse marking a reset event |
| cold | input | 1 | Qualifies `boot_start`: 1 for cold, 0 for warm |
| src_sel | input | 2 | Flash source code, sampled at `boot_start` |
| sw_state | input | 32 | Software state word checked on warm reset |
| fb_avail | input | 1 | Alternate boot source is available |
| ld_done | input | 1 | Loader finished the requested image |
| ld_crc_ok | input | 1 | CRC verdict, valid with `ld_done` |
| ld_req | output | 1 | Load request, held until `ld_done` |
| ld_idx | output | 2 | Index of the image requested |
| handoff | output | 1 | One-cycle pulse releasing the loaded image |
| fb_req | output | 1 | Request to boot from the alternate source |
| halt_err | output | 1 | Fallback needed but unavailable |
| last_idx | output | 2 | Last-loaded image index, survives warm resets |
| status | output | 16 | Exhaustion flag, started flag, source code |

## Verification
A wrong index register shows up on `ld_idx` in the very cycle the request starts, and on `last_idx` at the handoff pulse. A lost or stale exhaustion flag shows up at the next warm reset: a load request appears where only fallback should, or fallback appears too early. Both are visible one cycle after the `boot_start` pulse. The bench sweeps every pass/fail pattern over the four images with and without fallback available. It follows each pattern with magic and non-magic warm resets, so every path into and out of lockout is observed at the ports.

// File: rtl/boot_retry_seq.sv
module boot_retry_seq #(
  parameter int NIMG = 4,
  parameter logic [31:0] MAGIC = 32'h49535756,
  parameter int STW = 16,
  localparam int IW = $clog2(NIMG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           boot_start,
  input  logic           cold,
  input  logic [1:0]     src_sel,
  input  logic [31:0]    sw_state,
  input  logic           fb_avail,
  input  logic           ld_done,
  input  logic           ld_crc_ok,
  output logic           ld_req,
  output logic [IW-1:0]  ld_idx,
  output logic           handoff,
  output logic           fb_req,
  output logic           halt_err,
  output logic [IW-1:0]  last_idx,
  output logic [STW-1:0] status
);
  localparam logic [IW-1:0] LAST = IW'(NIMG - 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_HAND, S_RUN, S_FB, S_HALT} st_t;

  st_t          st;
  logic [IW-1:0] cur, last;
  logic         exh, started;
  logic [1:0]   src;

  assign ld_req   = (st == S_LOAD);
  assign ld_idx   = cur;
  assign handoff  = (st == S_HAND);
  assign fb_req   = (st == S_FB);
  assign halt_err = (st == S_HALT);
  assign last_idx = last;
  assign status   = STW'({2'b00, src, 6'b000000, started, exh});

  wire st_t fb_next = fb_avail ? S_FB : S_HALT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0;
      last <= '0;
      exh <= 1'b0;
      started <= 1'b0;
      src <= 2'b00;
    end else if (boot_start) begin
      src <= src_sel;
      started <= 1'b0;
      if (cold) begin
        exh <= 1'b0;
        last <= '0;
        cur <= '0;
        st <= S_LOAD;
      end else if (exh) begin
        st <= fb_next;
      end else if (sw_state == MAGIC) begin
        cur <= last;
        st <= S_LOAD;
      end else if (last == LAST) begin
        exh <= 1'b1;
        st <= fb_next;
      end else begin
        cur <= last + 1'b1;
        last <= last + 1'b1;
        st <= S_LOAD;
      end
    end else begin
      case (st)
        S_LOAD: if (ld_done) begin
          if (ld_crc_ok) begin
            last <= cur;
            st <= S_HAND;
          end else if (cur == LAST) begin
            exh <= 1'b1;
            st <= fb_next;
          end else begin
            cur <= cur + 1'b1;
          end
        end
        S_HAND: begin
          started <= 1'b1;
          st <= S_RUN;
        end
        default: st <= st;
      endcase
    end
  end

  a_r2_cold_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    boot_start && cold |=> ld_req && ld_idx == '0);

  a_r4_handoff_follows_pass: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |-> $past(ld_req && ld_done && ld_crc_ok && !boot_start));

  a_r4_handoff_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    handoff |=> !handoff);

  a_r6_warm_advance: assert property (@(posedge clk) disable iff (!rst_n)
    boot_start && !cold && !status[0] && sw_state != MAGIC && last_idx != LAST
    |=> last_idx == IW'($past(last_idx) + 1'b1) && ld_idx == last_idx);

  a_r7_last_fail_exhausts: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req && ld_done && !ld_crc_ok && ld_idx == LAST && !boot_start
    |=> status[0] && (fb_req || halt_err));

  a_r8_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    boot_start && !cold && status[0] |=> !ld_req && status[0]);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_req, handoff, fb_req, halt_err}));
endmodule

// File: tb/test_boot_retry_seq.sv
`timescale 1ns/1ps
module test_boot_retry_seq;
  localparam logic [31:0] MAGIC = 32'h49535756;

  logic clk = 1'b0, rst_n = 1'b0;
  logic boot_start = 1'b0, cold = 1'b0, fb_avail = 1'b0, ld_done = 1'b0, ld_crc_ok = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [31:0] sw_state = '0;
  logic ld_req, handoff, fb_req, halt_err;
  logic [1:0] ld_idx, last_idx;
  logic [15:0] status;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  boot_retry_seq i_boot_retry_seq (
    .clk(clk), .rst_n(rst_n), .boot_start(boot_start), .cold(cold),
    .src_sel(src_sel), .sw_state(sw_state), .fb_avail(fb_avail),
    .ld_done(ld_done), .ld_crc_ok(ld_crc_ok), .ld_req(ld_req), .ld_idx(ld_idx),
    .handoff(handoff), .fb_req(fb_req), .halt_err(halt_err),
    .last_idx(last_idx), .status(status)
  );

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_boot(input logic c, input logic [31:0] sw);
    boot_start = 1'b1; cold = c; sw_state = sw;
    tick();
    boot_start = 1'b0;
  endtask

  task automatic respond(input logic ok);
    ld_done = 1'b1; ld_crc_ok = ok;
    tick();
    ld_done = 1'b0; ld_crc_ok = 1'b0;
  endtask

  task automatic expect_hand(input int p);
    chk("R4 handoff high", handoff, 1);
    chk("R4 last_idx at handoff", last_idx, p);
    chk("R3 ld_req dropped", ld_req, 0);
    tick();
    chk("R4 handoff single cycle", handoff, 0);
    chk("R9 started bit", status[1], 1);
  endtask

  task automatic expect_fb(input logic fbv, input int src);
    chk("R7 exhausted bit", status[0], 1);
    chk("R7 fb_req", fb_req, fbv);
    chk("R10 halt_err", halt_err, !fbv);
    chk("R8 no load", ld_req, 0);
    chk("R9 source code", status[11:8], src);
    chk("R9 zero bits", {status[15:12], status[7:2]}, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 ld_req in reset", ld_req, 0);
    chk("R1 status in reset", status, 0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R1 ld_req idle", ld_req, 0);
    chk("R1 ld_idx idle", ld_idx, 0);
    chk("R1 handoff idle", handoff, 0);
    chk("R1 fb_req idle", fb_req, 0);
    chk("R1 halt_err idle", halt_err, 0);
    chk("R1 last_idx idle", last_idx, 0);
    chk("R1 status idle", status, 0);

    for (int fa = 0; fa < 2; fa++) begin
      for (int mask = 0; mask < 16; mask++) begin
        int p;
        int src;
        p = -1;
        src = mask % 3;
        fb_avail = fa[0];
        src_sel = src[1:0];
        do_boot(1'b1, 32'h0);
        chk("R2 ld_req after cold", ld_req, 1);
        chk("R8 cold clears exhausted", status[0], 0);
        chk("R9 started cleared", status[1], 0);
        chk("R9 source code", status[11:8], src);
        for (int i = 0; i < 4; i++) begin
          chk("R3 ld_idx sequence", ld_idx, i);
          respond(mask[i]);
          if (mask[i]) begin
            p = i;
            break;
          end
        end
        if (p < 0) begin
          expect_fb(fa[0], src);
          do_boot(1'b0, MAGIC);
          expect_fb(fa[0], src);
          continue;
        end
        expect_hand(p);

        do_boot(1'b0, MAGIC);
        chk("R5 reload request", ld_req, 1);
        chk("R5 reload index", ld_idx, p);
        chk("R9 started cleared on warm", status[1], 0);
        respond(1'b1);
        expect_hand(p);

        do_boot(1'b0, MAGIC ^ 32'h1);
        if (p < 3) begin
          chk("R6 advance request", ld_req, 1);
          chk("R6 advance index", ld_idx, p + 1);
          chk("R6 last_idx incremented", last_idx, p + 1);
          respond(1'b0);
          if (p + 1 < 3) begin
            chk("R3 next after warm fail", ld_idx, p + 2);
            respond(1'b1);
            expect_hand(p + 2);
          end else begin
            expect_fb(fa[0], src);
          end
        end else begin
          expect_fb(fa[0], src);
          chk("R7 last_idx kept", last_idx, 3);
          do_boot(1'b0, MAGIC);
          expect_fb(fa[0], src);
          tick();
          chk("R8 lockout held", ld_req, 0);
        end
      end
    end

    fb_avail = 1'b0;
    do_boot(1'b1, 32'h0);
    respond(1'b0); respond(1'b0); respond(1'b0); respond(1'b0);
    chk("R10 halt", halt_err, 1);
    chk("R10 no fb_req", fb_req, 0);
    fb_avail = 1'b1;
    tick();
    chk("R10 halt sticky", halt_err, 1);
    do_boot(1'b1, 32'h0);
    chk("R8 cold after halt", ld_req, 1);
    chk("R8 cold clears last_idx", last_idx, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule